// File: doc/BRIEF.md
# Multiword Field Select Extractor

This block pulls a bit field out of an operand of one to four 25-bit words and writes the result into a chosen subset of four one-word registers. Each word has a sign bit at the top (vector index 24) and 24 data bits at positions 1 to 24 (vector indices 0 to 23). Two 5-bit boundary codes mark the field. The left boundary is the most significant bit of the field and sits in the first word. The right boundary is the least significant bit of the field and sits in the last word. Both codes carry a bias of three, so bit position p is coded as p+3. Every bit outside the field is returned as zero, and every sign bit is returned as zero, which makes the result positive.

A 4-bit designation mask says which registers take part. The number of set bits is the number of operand words. The words arrive in address order on one flat input bus. Word 0 has the lowest address and is the most significant word. The last word goes to the highest-numbered designated register, and each earlier word goes to the next lower designated register. The designated registers do not have to be adjacent.

Results appear one clock after a start pulse, together with one cycle of write enables. An illegal request raises an error pulse instead, and no register is written.

Top module: `fsx_extract`

## Requirements
- R1: A boundary code c is legal when 4 <= c <= 27 (binary 00100 to 11011) and then selects bit position c-3. Code 27 is position 24 and code 4 is position 1.
- R2: A left or right code outside 4..27 raises the error output and suppresses every register write.
- R3: The sign bit (index 24) of every register is always 0, and it is forced to 0 on every write, whatever the operand's sign bit is.
- R4: With one word, data positions from the right boundary up to the left boundary are copied and all other data bits are zero. Equal boundaries select a single bit.
- R5: With one word, a left position lower than the right position is flagged as an error and nothing is written.
- R6: With two or more words, the first word keeps positions 1..left, the last word keeps positions right..24, and every middle word keeps all 24 data bits. The left position may be lower than the right position here.
- R7: Designation bits 3, 2, 1 and 0 select registers AR1, AR2, AR3 and AR4. Register ARr is output on reg_o[(r-1)*25 +: 25] and has write enable we_o[r-1]. Operand word k is word_i[k*25 +: 25]. The k-th designated register in ascending number order receives word k.
- R8: A register that is not written keeps its value.
- R9: Register values, write enables and the error flag update on the first clock edge after start_i is sampled high. Write enables and the error flag are high for that one cycle only.
- R10: A start with a designation mask of zero raises the error output and writes nothing.
- R11: Reset clears all four registers, the write enables and the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, sampled on the rising edge |
| word_i | input | 100 | Operand words; word k at bits k*25 +: 25, word 0 most significant |
| desig_i | input | 4 | Register designation; bit 3 = AR1 ... bit 0 = AR4 |
| left_code_i | input | 5 | Left (most significant) boundary code, bias 3 |
| right_code_i | input | 5 | Right (least significant) boundary code, bias 3 |
| reg_o | output | 100 | Register contents; ARr at bits (r-1)*25 +: 25 |
| we_o | output | 4 | One-cycle write enables; bit r-1 = ARr |
| err_o | output | 1 | One-cycle error flag for an illegal request |

## Verification
Some rules are checked by assertions on every cycle. Sign bits stay clear. Registers without a write enable hold their value. Enables and the error flag are high only after a start. An illegal code, an empty mask, or a reversed single-word range always gives an error with no writes. The lane mask builders keep the first word below the left edge and the last word above the right edge. Only the bench scenarios can show that the right operand word reaches the right register for non-adjacent masks, and that middle words pass through whole. The exact field contents at the extreme codes are also left to the bench, where they are compared with an independent model.

// File: rtl/fsx_pkg.sv
package fsx_pkg;
    localparam int NREG      = 4;
    localparam int DATA_W    = 24;
    localparam int WORD_W    = DATA_W + 1;
    localparam int CODE_W    = 5;
    localparam int CODE_BIAS = 3;
    localparam int POS_W     = $clog2(DATA_W + 1);
    localparam int IDX_W     = $clog2(NREG);
    localparam int CNT_W     = $clog2(NREG + 1);

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t [NREG-1:0] regs;
        logic  [NREG-1:0] we;
        logic             err;
    } fsx_state_t;
endpackage

// File: rtl/fsx_bound_decode.sv
module fsx_bound_decode #(
    parameter int CODE_W    = 5,
    parameter int POS_W     = 5,
    parameter int CODE_BIAS = 3,
    parameter int DATA_W    = 24
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [POS_W-1:0]  pos_o,
    output logic              legal_o
);
    localparam int LOW_CODE  = CODE_BIAS + 1;
    localparam int HIGH_CODE = CODE_BIAS + DATA_W;

    logic [CODE_W-1:0] unbiased;

    always_comb begin
        unbiased = code_i - CODE_W'(CODE_BIAS);
        legal_o  = (int'(code_i) >= LOW_CODE) && (int'(code_i) <= HIGH_CODE);
        pos_o    = legal_o ? POS_W'(unbiased) : '0;
    end

    always_comb begin
        if (legal_o) begin
            AST_POS_IN_RANGE: assert (int'(pos_o) >= 1 && int'(pos_o) <= DATA_W); // R1
        end
    end
endmodule

// File: rtl/fsx_route.sv
module fsx_route #(
    parameter int NREG  = 4,
    parameter int IDX_W = 2,
    parameter int CNT_W = 3
) (
    input  logic [NREG-1:0]             desig_i,
    output logic [NREG-1:0]             sel_o,
    output logic [NREG-1:0][IDX_W-1:0]  idx_o,
    output logic [CNT_W-1:0]            count_o
);
    // Designation bit NREG-1 names the lowest-numbered register.
    for (genvar r = 0; r < NREG; r++) begin : g_sel
        assign sel_o[r] = desig_i[NREG-1-r];
    end

    always_comb begin
        logic [CNT_W-1:0] run;
        run = '0;
        for (int r = 0; r < NREG; r++) begin
            idx_o[r] = IDX_W'(run);
            if (sel_o[r]) run = run + 1'b1;
        end
        count_o = run;
    end

    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            if (sel_o[r]) begin
                AST_IDX_BELOW_COUNT: assert (CNT_W'(idx_o[r]) < count_o); // R7
            end
        end
    end
endmodule

// File: rtl/fsx_lane_mask.sv
module fsx_lane_mask #(
    parameter int DATA_W = 24,
    parameter int POS_W  = 5,
    parameter int IDX_W  = 2,
    parameter int CNT_W  = 3
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [POS_W-1:0]  left_pos_i,
    input  logic [POS_W-1:0]  right_pos_i,
    output logic [DATA_W-1:0] mask_o
);
    logic is_first;
    logic is_last;

    assign is_first = (idx_i == '0);
    assign is_last  = (CNT_W'(idx_i) + 1'b1 == count_i);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic under_left;
        logic over_right;
        assign under_left  = (b + 1) <= int'(left_pos_i);
        assign over_right  = (b + 1) >= int'(right_pos_i);
        assign mask_o[b]   = (!is_first || under_left) && (!is_last || over_right);
    end

    always_comb begin
        if (is_first) begin
            AST_LEFT_EDGE: assert ((mask_o >> left_pos_i) == '0); // R6
        end
        if (is_last && right_pos_i != '0) begin
            AST_RIGHT_EDGE: assert ((mask_o << (DATA_W + 1 - int'(right_pos_i))) == '0); // R6
        end
    end
endmodule

// File: rtl/fsx_extract.sv
module fsx_extract
    import fsx_pkg::*;
#(
    parameter int P_NREG   = NREG,
    parameter int P_DATA_W = DATA_W,
    parameter int P_CODE_W = CODE_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [P_NREG*(P_DATA_W+1)-1:0] word_i,
    input  logic [P_NREG-1:0]             desig_i,
    input  logic [P_CODE_W-1:0]           left_code_i,
    input  logic [P_CODE_W-1:0]           right_code_i,
    output logic [P_NREG*(P_DATA_W+1)-1:0] reg_o,
    output logic [P_NREG-1:0]             we_o,
    output logic                          err_o
);
    localparam int L_WORD_W = P_DATA_W + 1;
    localparam int L_POS_W  = $clog2(P_DATA_W + 1);
    localparam int L_IDX_W  = (P_NREG > 1) ? $clog2(P_NREG) : 1;
    localparam int L_CNT_W  = $clog2(P_NREG + 1);

    typedef struct packed {
        logic [P_NREG-1:0][L_WORD_W-1:0] regs;
        logic [P_NREG-1:0]               we;
        logic                            err;
    } state_t;

    state_t state_d, state_q;

    logic [L_POS_W-1:0] left_pos, right_pos;
    logic               left_ok, right_ok;
    logic [P_NREG-1:0]              sel;
    logic [P_NREG-1:0][L_IDX_W-1:0] idx;
    logic [L_CNT_W-1:0]             count;
    logic [P_DATA_W-1:0]            lane_mask [P_NREG];
    logic [L_WORD_W-1:0]            word_arr  [P_NREG];
    logic                           bad_req;

    fsx_bound_decode #(
        .CODE_W(P_CODE_W), .POS_W(L_POS_W), .CODE_BIAS(CODE_BIAS), .DATA_W(P_DATA_W)
    ) u_left_dec (
        .code_i(left_code_i), .pos_o(left_pos), .legal_o(left_ok)
    );

    fsx_bound_decode #(
        .CODE_W(P_CODE_W), .POS_W(L_POS_W), .CODE_BIAS(CODE_BIAS), .DATA_W(P_DATA_W)
    ) u_right_dec (
        .code_i(right_code_i), .pos_o(right_pos), .legal_o(right_ok)
    );

    fsx_route #(
        .NREG(P_NREG), .IDX_W(L_IDX_W), .CNT_W(L_CNT_W)
    ) u_route (
        .desig_i(desig_i), .sel_o(sel), .idx_o(idx), .count_o(count)
    );

    for (genvar r = 0; r < P_NREG; r++) begin : g_lane
        assign word_arr[r] = word_i[r*L_WORD_W +: L_WORD_W];

        fsx_lane_mask #(
            .DATA_W(P_DATA_W), .POS_W(L_POS_W), .IDX_W(L_IDX_W), .CNT_W(L_CNT_W)
        ) u_mask (
            .idx_i(idx[r]), .count_i(count),
            .left_pos_i(left_pos), .right_pos_i(right_pos),
            .mask_o(lane_mask[r])
        );

        assign reg_o[r*L_WORD_W +: L_WORD_W] = state_q.regs[r];
    end

    assign bad_req = !left_ok || !right_ok || (count == '0)
                   || ((count == L_CNT_W'(1)) && (left_pos < right_pos));

    always_comb begin
        state_d     = state_q;
        state_d.we  = '0;
        state_d.err = 1'b0;
        if (start_i) begin
            if (bad_req) begin
                state_d.err = 1'b1;
            end else begin
                for (int r = 0; r < P_NREG; r++) begin
                    if (sel[r]) begin
                        state_d.regs[r] = {1'b0, word_arr[idx[r]][P_DATA_W-1:0] & lane_mask[r]};
                        state_d.we[r]   = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign we_o  = state_q.we;
    assign err_o = state_q.err;

    AST_BAD_CODE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && (!left_ok || !right_ok) |=> err_o && (we_o == '0)); // R2

    AST_SINGLE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && left_ok && right_ok && (count == L_CNT_W'(1)) && (left_pos < right_pos)
        |=> err_o && (we_o == '0)); // R5

    AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && (desig_i == '0) |=> err_o && (we_o == '0)); // R10

    AST_PULSE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (we_o == '0) && !err_o); // R9

    for (genvar r = 0; r < P_NREG; r++) begin : g_chk
        AST_SIGN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            reg_o[r*L_WORD_W + P_DATA_W] == 1'b0); // R3
        AST_HOLD_UNWRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
            !we_o[r] |-> $stable(reg_o[r*L_WORD_W +: L_WORD_W])); // R8
    end
endmodule

// File: tb/fsx_extract_tb.sv
module fsx_extract_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;
    localparam int WW = 25;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [NW*WW-1:0]  word_i = '0;
    logic [NW-1:0]     desig_i = '0;
    logic [4:0]        left_code_i = '0;
    logic [4:0]        right_code_i = '0;
    logic [NW*WW-1:0]  reg_o;
    logic [NW-1:0]     we_o;
    logic              err_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [NW*WW-1:0] shadow = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsx_extract dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(word_i),
        .desig_i(desig_i), .left_code_i(left_code_i), .right_code_i(right_code_i),
        .reg_o(reg_o), .we_o(we_o), .err_o(err_o)
    );

    task automatic check(input bit ok, input string req, input logic [NW*WW-1:0] act,
                         input logic [NW*WW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Independent model of one request.
    task automatic model(input logic [NW*WW-1:0] w, input logic [3:0] d,
                         input logic [4:0] lc, input logic [4:0] rc,
                         inout logic [NW*WW-1:0] regs,
                         output logic [3:0] we, output logic e);
        int lp, rp, n, k;
        lp = int'(lc) - 3;
        rp = int'(rc) - 3;
        n  = $countones(d);
        we = '0;
        e  = 1'b0;
        if (lc < 4 || lc > 27 || rc < 4 || rc > 27 || n == 0 || (n == 1 && lp < rp)) begin
            e = 1'b1;
        end else begin
            k = 0;
            for (int r = 0; r < NW; r++) begin
                if (d[3-r]) begin
                    logic [WW-1:0] src, res;
                    src = w[k*WW +: WW];
                    res = '0;
                    for (int p = 1; p <= 24; p++) begin
                        if ((k != 0 || p <= lp) && (k != n-1 || p >= rp)) res[p-1] = src[p-1];
                    end
                    regs[r*WW +: WW] = res;
                    we[r] = 1'b1;
                    k++;
                end
            end
        end
    endtask

    task automatic run_op(input logic [NW*WW-1:0] w, input logic [3:0] d,
                          input logic [4:0] lc, input logic [4:0] rc, input string tag);
        logic [3:0] exp_we;
        logic       exp_err;
        model(w, d, lc, rc, shadow, exp_we, exp_err);
        @(negedge clk);
        word_i = w; desig_i = d; left_code_i = lc; right_code_i = rc; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(reg_o == shadow, {tag, " regs"}, reg_o, shadow);
        check(we_o == exp_we && err_o == exp_err, {tag, " we/err"},
              {95'b0, we_o, err_o}, {95'b0, exp_we, exp_err});
        @(negedge clk);
        check(we_o == '0 && err_o == 1'b0 && reg_o == shadow, "R9 pulse ends",
              {95'b0, we_o, err_o}, '0);
    endtask

    function automatic logic [NW*WW-1:0] rnd_words();
        logic [NW*WW-1:0] v;
        for (int i = 0; i < NW; i++) v[i*WW +: WW] = WW'($urandom);
        return v;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [NW*WW-1:0] w;
        logic [4:0] lc, rc;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check(reg_o == '0 && we_o == '0 && err_o == 1'b0, "R11 reset", reg_o, '0);
        rst_n = 1'b1;

        w = {4{25'h1FF_FFFF}};
        run_op(w, 4'b0100, 5'd13, 5'd13, "R4 single bit");
        run_op(w, 4'b0001, 5'd27, 5'd4, "R1 R3 full width codes 27/4");
        run_op(rnd_words(), 4'b1010, 5'd8, 5'd23, "R7 R6 nonadjacent");
        run_op(rnd_words(), 4'b1111, 5'd6, 5'd25, "R6 four words");
        run_op(w, 4'b0111, 5'd10, 5'd12, "R6 middle word whole");
        run_op(rnd_words(), 4'b1001, 5'd5, 5'd23, "R6 multiword left<right");
        run_op(rnd_words(), 4'b1111, 5'd3, 5'd10, "R2 R8 left code low");
        run_op(rnd_words(), 4'b1111, 5'd20, 5'd28, "R2 R8 right code high");
        run_op(rnd_words(), 4'b0010, 5'd9, 5'd15, "R5 reversed single");
        run_op(rnd_words(), 4'b0000, 5'd20, 5'd10, "R10 empty mask");
        run_op(rnd_words(), 4'b1000, 5'd20, 5'd10, "R7 R4 only AR1");

        for (int i = 0; i < 300; i++) begin
            lc = ($urandom_range(0, 9) == 0) ? 5'($urandom) : 5'($urandom_range(4, 27));
            rc = ($urandom_range(0, 9) == 0) ? 5'($urandom) : 5'($urandom_range(4, 27));
            run_op(rnd_words(), 4'($urandom), lc, rc, "R7 R6 R8 random");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule